// File: doc/BRIEF.md
# Three-Line GPIO Port

This block is a small general-purpose I/O port with three lines. Software reaches it through a byte-wide register bus that has an address, a write strobe, write data and combinational read data. Three registers set up and observe the lines. The direction register selects, for each line, whether the line is an input or an output. The output register holds the levels driven onto lines configured as outputs. The input register returns the sampled external levels.

Each line's output enable comes straight from its direction bit, with a set bit meaning input. The pin value always follows the output register, so a line that is switched to output drives the value already stored there. External levels pass through a two-stage synchronizer and are then stored. A read of the input register also shows the levels being driven on output lines, because the sampled pin state is ORed with the driven values. Changes on input lines raise no event of any kind.

Top module: `gpio3_port`

## Requirements
- R1: After reset the direction register reads 0x07 (all lines inputs), the output register reads 0x00, and pin_oe is 3'b000.
- R2: A write to address 0 stores wdata AND 0x67 in the direction register. Bits 5 and 6 are kept as plain storage, and a read of address 0 returns the stored byte.
- R3: A write to address 2 stores wdata[2:0] in the output register. A read of address 2 returns those bits with bits [7:3] zero.
- R4: For each line i, pin_oe[i] is the inverse of direction bit i, and pin_out[i] equals output register bit i whatever the direction.
- R5: A read of address 1 returns, in bits [2:0], the synchronized pin levels ORed with (NOT direction[2:0] AND output[2:0]). Bits [7:3] read zero.
- R6: A level change on pin_in shows up in the address-1 readback after the third rising clock edge, and not after the second.
- R7: Writes to address 1 and to address 3 change neither the direction nor the output register. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0 direction, 1 input, 2 output, 3 unused |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, combinational |
| pin_in | input | 3 | External line levels, asynchronous |
| pin_out | output | 3 | Driven line values |
| pin_oe | output | 3 | Per-line output enable, high when the line drives |

## Verification
The assertions assume that addr, wr_en and wdata are stable around each rising edge and change only between edges. The stimulus meets this by driving all bus inputs on falling edges. pin_in is asynchronous by intent, so no assertion ties it to a fixed cycle. The stimulus also changes it only on falling edges, which makes the three-edge latency exact and lets it be checked on both sides. The sweep covers every combination of direction, output value and pin level.

// File: rtl/gpio3_port.sv
module gpio3_port #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  DIR_MASK    = 8'h67,
  parameter logic [7:0]  DIR_RESET   = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [2:0] pin_in,
  output logic [2:0] pin_out,
  output logic [2:0] pin_oe
);
  localparam logic [1:0] A_DIR = 2'd0;
  localparam logic [1:0] A_IN  = 2'd1;
  localparam logic [1:0] A_OUT = 2'd2;

  logic [7:0] dir_q;
  logic [2:0] out_q;
  logic [2:0] in_q;
  logic [2:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= DIR_RESET;
      out_q <= 3'b000;
    end else if (wr_en) begin
      if (addr == A_DIR) dir_q <= wdata & DIR_MASK;
      if (addr == A_OUT) out_q <= wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b000;
      in_q <= 3'b000;
    end else begin
      sync_q[0] <= pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      in_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_oe  = ~dir_q[2:0];
  assign pin_out = out_q;

  always_comb begin
    case (addr)
      A_DIR:   rdata = dir_q;
      A_IN:    rdata = {5'b0, in_q | (~dir_q[2:0] & out_q)};
      A_OUT:   rdata = {5'b0, out_q};
      default: rdata = 8'h00;
    endcase
  end

  a_r2_dir_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> (dir_q == ($past(wdata) & DIR_MASK)));

  a_r3_out_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_OUT) |=> (pin_out == $past(wdata[2:0])));

  a_r7_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_IN || addr == 2'd3)) |=> ($stable(pin_oe) && $stable(pin_out)));

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_IN || addr == A_OUT) |-> (rdata[7:3] == 5'b0));

  a_r4_oe_tracks_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_DIR) |=> $stable(pin_oe));
endmodule

// File: tb/gpio3_port_bench.sv
module gpio3_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] pin_in = 3'b000;
  logic [2:0] pin_out;
  logic [2:0] pin_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio3_port u_gpio3_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R1 dir reset", v, 8'h07);
    rd(2'd2, v); check("R1 out reset", v, 8'h00);
    check("R1 oe reset", {5'b0, pin_oe}, 8'h00);

    for (int d = 0; d < 256; d++) begin
      wr(2'd0, d[7:0]);
      rd(2'd0, v); check("R2 dir mask", v, d[7:0] & 8'h67);
      check("R4 oe", {5'b0, pin_oe}, {5'b0, ~d[2:0]});
    end

    for (int d = 0; d < 256; d++) begin
      wr(2'd2, d[7:0]);
      rd(2'd2, v); check("R3 out store", v, {5'b0, d[2:0]});
      check("R4 pin_out", {5'b0, pin_out}, {5'b0, d[2:0]});
    end

    for (int d = 0; d < 8; d++)
      for (int o = 0; o < 8; o++) begin
        wr(2'd0, {5'b01100, d[2:0]});
        wr(2'd2, {5'b11111, o[2:0]});
        for (int p = 0; p < 8; p++) begin
          pin_in = p[2:0];
          repeat (4) @(negedge clk);
          rd(2'd1, v);
          check("R5 input readback", v, {5'b0, p[2:0] | (~d[2:0] & o[2:0])});
          check("R4 oe sweep", {5'b0, pin_oe}, {5'b0, ~d[2:0]});
          check("R4 pin_out sweep", {5'b0, pin_out}, {5'b0, o[2:0]});
        end
      end

    wr(2'd0, 8'h07);
    pin_in = 3'b000;
    repeat (4) @(negedge clk);
    pin_in = 3'b101;
    @(negedge clk); @(negedge clk);
    rd(2'd1, v); check("R6 not after two edges", v, 8'h00);
    @(negedge clk);
    rd(2'd1, v); check("R6 after three edges", v, 8'h05);

    wr(2'd0, 8'h62);
    wr(2'd2, 8'h05);
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd0, v); check("R7 dir kept", v, 8'h62);
    rd(2'd2, v); check("R7 out kept", v, 8'h05);
    rd(2'd3, v); check("R7 addr3 reads zero", v, 8'h00);
    check("R7 pins kept", {2'b0, pin_oe, pin_out}, {2'b0, 3'b101, 3'b101});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule